// File: doc/BRIEF.md
# Trap Return Unit

This block carries out the two ways a 64-bit processor leaves a trap handler. On a return request it reads the trap-stack entry that belongs to the current trap level. An entry holds a saved program counter, a saved next program counter and a packed 64-bit saved-state word. From the entry the block restores the program counter pair, both condition-code nibbles, the address-space identifier, the 12-bit processor-state register and the window pointer. It then lowers the trap level by one. The "done" flavour resumes after the trapping instruction. The "retry" flavour re-executes it.

The processor-state register also decides which of four global register banks is active. The active bank is reached through one write port and one registered read port. A separate processor-state write port lets software change the state, and with it the bank, outside a trap return. The trap stack is a small synchronous RAM inside the block, written through its own port. Every processor-state update raises a one-cycle pulse that tells the interrupt logic to look again.

A return request is taken on a clock edge. The trap-stack read is registered on that edge, and the restored values appear on the outputs after the following edge.

Top module: `trap_return_unit`

## Requirements
- R1: On a done request the program counter is loaded with the saved next-PC, and the next-PC with the saved next-PC plus 4, modulo 2^XW.
- R2: On a retry request (`op_retry`=1) the program counter is loaded with the saved PC, and the next-PC with the saved next-PC.
- R3: From the saved-state word, bits 39:36 go to `xcc` (64-bit flags), bits 35:32 go to `icc` (32-bit flags) and bits 31:24 go to `asi`.
- R4: The processor state is loaded from saved-state bits 19:8 ANDed with 0xF3F. When `GL_ONLY` is 1, bit 0 is also cleared. The same rule applies to `ps_wdata`.
- R5: Let v be saved-state bits 7:0, replaced by v mod NWIN when v is NWIN or more. `cwp` becomes NWIN-1-v.
- R6: The entry for trap level L sits at trap-stack address L-1. Each accepted request lowers `tl` by one. The results show after the second rising edge that follows the edge taking the request.
- R7: `gbank` follows processor-state bits {11,10,0}. Exactly bit 0 gives 1 (alternate). Exactly bit 10 gives 2 (MMU). Exactly bit 11 gives 3 (interrupt). Any other combination gives 0 (normal). Global accesses use the active bank, and every bank keeps its contents across switches. The read data is registered and is read-first.
- R8: A `ps_we` pulse loads the masked `ps_wdata` into `pstate` and updates `gbank` on the next edge.
- R9: A request made while `tl` is 0 changes no state. `tl_err` goes high for one cycle instead.
- R10: `irq_recheck` goes high for exactly the cycle after each processor-state update, whether from a trap return or from `ps_wdata`.
- R11: While a request is in its apply cycle, the block ignores a further request, `ps_we` and `tl_we`. The trap return has priority.
- R12: Synchronous reset clears `pc`, `npc`, the flags, `asi`, `pstate`, `cwp`, `tl`, `gbank`, `irq_recheck` and `tl_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_we | input | 1 | Trap-stack entry write strobe |
| ts_waddr | input | SAW | Entry address (trap level minus one) |
| ts_wtpc | input | XW | Saved PC to store |
| ts_wtnpc | input | XW | Saved next-PC to store |
| ts_wtstate | input | 64 | Packed saved-state word to store |
| tl_we | input | 1 | Trap-level write strobe |
| tl_wdata | input | TLW | New trap level |
| ps_we | input | 1 | Processor-state write strobe |
| ps_wdata | input | 12 | New processor state, before masking |
| op_valid | input | 1 | Trap-return request |
| op_retry | input | 1 | 1 = retry, 0 = done |
| g_we | input | 1 | Global register write strobe, active bank |
| g_widx | input | GIW | Global register write index |
| g_wdata | input | XW | Global register write data |
| g_ridx | input | GIW | Global register read index |
| g_rdata | output | XW | Registered global read data, active bank |
| pc | output | XW | Program counter |
| npc | output | XW | Next program counter |
| xcc | output | 4 | 64-bit condition flags |
| icc | output | 4 | 32-bit condition flags |
| asi | output | 8 | Address-space identifier |
| pstate | output | 12 | Processor state |
| cwp | output | CW | Window pointer |
| tl | output | TLW | Trap level |
| gbank | output | 2 | Active global bank |
| irq_recheck | output | 1 | Interrupt re-evaluation pulse |
| tl_err | output | 1 | Request at trap level 0 |

## Verification
Some properties are checked on every cycle: the masking of the processor state, `gbank` staying in step with `pstate`, a single-step fall of `tl` after each apply cycle, the next-PC offset after a done, the one-cycle apply window, the source of each recheck pulse, and the program counter holding still outside an apply. Other behaviour only the bench scenarios can show. This covers the exact unpacking of field values and the window-pointer reversal including the modulo case. It also covers bank contents being kept across switches, next-PC wrap-around, and the level-0 error. The dropped second request and the dropped processor-state write in the apply cycle are checked the same way.

// File: rtl/trp_pkg.sv
package trp_pkg;

  localparam logic [11:0] PS_KEEP = 12'hF3F;
  localparam logic [11:0] PS_BSEL = 12'hC01;

  typedef enum logic [1:0] {
    BANK_NORM = 2'd0,
    BANK_ALT  = 2'd1,
    BANK_MMU  = 2'd2,
    BANK_INTR = 2'd3
  } gbank_e;

  function automatic gbank_e bank_of(input logic [11:0] ps);
    case (ps & PS_BSEL)
      12'h001: return BANK_ALT;
      12'h400: return BANK_MMU;
      12'h800: return BANK_INTR;
      default: return BANK_NORM;
    endcase
  endfunction

  function automatic logic [11:0] ps_clean(input logic [11:0] raw, input logic gl_only);
    logic [11:0] v;
    v = raw & PS_KEEP;
    if (gl_only) v[0] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/trp_ram.sv
module trp_ram #(
  parameter int DEPTH = 4,
  parameter int DW    = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/trp_unpack.sv
module trp_unpack
  import trp_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter bit GL_ONLY = 1'b0,
  localparam int CW     = $clog2(NWIN)
) (
  input  logic [7:0]    ccr_in,
  input  logic [7:0]    asi_in,
  input  logic [11:0]   ps_in,
  input  logic [7:0]    win_in,
  output logic [3:0]    xcc_o,
  output logic [3:0]    icc_o,
  output logic [7:0]    asi_o,
  output logic [11:0]   ps_o,
  output logic [CW-1:0] cwp_o
);

  logic [7:0] win_r;

  always_comb begin
    xcc_o = ccr_in[7:4];
    icc_o = ccr_in[3:0];
    asi_o = asi_in;
    ps_o  = ps_clean(ps_in, GL_ONLY);
    if (int'(win_in) >= NWIN) win_r = 8'(int'(win_in) % NWIN);
    else                      win_r = win_in;
    cwp_o = CW'(NWIN - 1) - CW'(win_r);
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trp_pkg::*;
#(
  parameter int XW      = 64,
  parameter int NWIN    = 8,
  parameter int MAXTL   = 4,
  parameter int NGREG   = 8,
  parameter bit GL_ONLY = 1'b0,
  localparam int SAW    = (MAXTL > 1) ? $clog2(MAXTL) : 1,
  localparam int TLW    = $clog2(MAXTL + 1),
  localparam int CW     = $clog2(NWIN),
  localparam int GIW    = $clog2(NGREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts_we,
  input  logic [SAW-1:0]   ts_waddr,
  input  logic [XW-1:0]    ts_wtpc,
  input  logic [XW-1:0]    ts_wtnpc,
  input  logic [63:0]      ts_wtstate,
  input  logic             tl_we,
  input  logic [TLW-1:0]   tl_wdata,
  input  logic             ps_we,
  input  logic [11:0]      ps_wdata,
  input  logic             op_valid,
  input  logic             op_retry,
  input  logic             g_we,
  input  logic [GIW-1:0]   g_widx,
  input  logic [XW-1:0]    g_wdata,
  input  logic [GIW-1:0]   g_ridx,
  output logic [XW-1:0]    g_rdata,
  output logic [XW-1:0]    pc,
  output logic [XW-1:0]    npc,
  output logic [3:0]       xcc,
  output logic [3:0]       icc,
  output logic [7:0]       asi,
  output logic [11:0]      pstate,
  output logic [CW-1:0]    cwp,
  output logic [TLW-1:0]   tl,
  output logic [1:0]       gbank,
  output logic             irq_recheck,
  output logic             tl_err
);

  // Entry keeps only the saved-state bits that are restored: 39:24 and 19:0.
  localparam int SSW = 36;
  localparam int EW  = 2 * XW + SSW;
  localparam int GAW = 2 + GIW;

  logic          busy_q, retry_q;
  logic [EW-1:0] ent_q;
  gbank_e        bank_q;
  logic          take;

  logic [XW-1:0] e_tpc, e_tnpc;
  logic [3:0]    u_xcc, u_icc;
  logic [7:0]    u_asi;
  logic [11:0]   u_ps, w_ps;
  logic [CW-1:0] u_cwp;

  wire unused_tstate_bits = ^{ts_wtstate[63:40], ts_wtstate[23:20]};

  assign take  = op_valid && !busy_q && (tl != '0);
  assign gbank = bank_q;
  assign w_ps  = ps_clean(ps_wdata, GL_ONLY);

  trp_ram #(.DEPTH(MAXTL), .DW(EW)) u_stack (
    .clk   (clk),
    .we    (ts_we),
    .waddr (ts_waddr),
    .wdata ({ts_wtpc, ts_wtnpc, ts_wtstate[39:24], ts_wtstate[19:0]}),
    .re    (take),
    .raddr (SAW'(tl - TLW'(1))),
    .rdata (ent_q)
  );

  assign e_tpc  = ent_q[EW-1 -: XW];
  assign e_tnpc = ent_q[SSW +: XW];

  trp_unpack #(.NWIN(NWIN), .GL_ONLY(GL_ONLY)) u_unpack (
    .ccr_in (ent_q[35:28]),
    .asi_in (ent_q[27:20]),
    .ps_in  (ent_q[19:8]),
    .win_in (ent_q[7:0]),
    .xcc_o  (u_xcc),
    .icc_o  (u_icc),
    .asi_o  (u_asi),
    .ps_o   (u_ps),
    .cwp_o  (u_cwp)
  );

  trp_ram #(.DEPTH(4 * NGREG), .DW(XW)) u_gregs (
    .clk   (clk),
    .we    (g_we),
    .waddr (GAW'({bank_q, g_widx})),
    .wdata (g_wdata),
    .re    (1'b1),
    .raddr (GAW'({bank_q, g_ridx})),
    .rdata (g_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      retry_q     <= 1'b0;
      pc          <= '0;
      npc         <= '0;
      xcc         <= '0;
      icc         <= '0;
      asi         <= '0;
      pstate      <= '0;
      cwp         <= '0;
      tl          <= '0;
      bank_q      <= BANK_NORM;
      irq_recheck <= 1'b0;
      tl_err      <= 1'b0;
    end else begin
      irq_recheck <= 1'b0;
      tl_err      <= op_valid && !busy_q && (tl == '0);
      busy_q      <= take;
      if (take) retry_q <= op_retry;
      if (busy_q) begin
        pc          <= retry_q ? e_tpc : e_tnpc;
        npc         <= retry_q ? e_tnpc : e_tnpc + XW'(4);
        xcc         <= u_xcc;
        icc         <= u_icc;
        asi         <= u_asi;
        pstate      <= u_ps;
        cwp         <= u_cwp;
        tl          <= tl - TLW'(1);
        bank_q      <= bank_of(u_ps);
        irq_recheck <= 1'b1;
      end else begin
        if (tl_we) tl <= tl_wdata;
        if (ps_we) begin
          pstate      <= w_ps;
          bank_q      <= bank_of(w_ps);
          irq_recheck <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trp_checker.sv
module trp_checker
  import trp_pkg::*;
#(
  parameter int XW      = 64,
  parameter int MAXTL   = 4,
  parameter bit GL_ONLY = 1'b0,
  localparam int TLW    = $clog2(MAXTL + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic           tl_we,
  input logic           ps_we,
  input logic           busy,
  input logic           retry,
  input logic [TLW-1:0] tl,
  input logic [XW-1:0]  pc,
  input logic [XW-1:0]  npc,
  input logic [11:0]    pstate,
  input logic [1:0]     gbank,
  input logic           irq,
  input logic           tl_err
);

  AST_DONE_NPC: assert property (@(posedge clk) disable iff (rst) (busy && !retry) |=> (npc == pc + XW'(4))); // R1
  AST_PS_MASK: assert property (@(posedge clk) disable iff (rst) ((pstate & ~PS_KEEP) == 12'h0) && (!GL_ONLY || !pstate[0])); // R4
  AST_TL_STEP: assert property (@(posedge clk) disable iff (rst) busy |=> (tl == $past(tl) - TLW'(1))); // R6
  AST_BANK_TRACK: assert property (@(posedge clk) disable iff (rst) (gbank == bank_of(pstate))); // R7
  AST_IDLE_ERR: assert property (@(posedge clk) disable iff (rst) (op_valid && !busy && !tl_we && tl == '0) |=> (tl_err && !irq && tl == '0)); // R9
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(pc)); // R9
  AST_RECHECK_SRC: assert property (@(posedge clk) disable iff (rst) irq |-> ($past(busy) || $past(ps_we))); // R10
  AST_ONE_APPLY: assert property (@(posedge clk) disable iff (rst) busy |=> !busy); // R11

endmodule

bind trap_return_unit trp_checker #(.XW(XW), .MAXTL(MAXTL), .GL_ONLY(GL_ONLY)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .tl_we    (tl_we),
  .ps_we    (ps_we),
  .busy     (busy_q),
  .retry    (retry_q),
  .tl       (tl),
  .pc       (pc),
  .npc      (npc),
  .pstate   (pstate),
  .gbank    (gbank),
  .irq      (irq_recheck),
  .tl_err   (tl_err)
);

// File: tb/tb_trap_return_unit.sv
`timescale 1ns/1ps
module tb_trap_return_unit;
  localparam int XW = 64, NWIN = 8, MAXTL = 4, NGREG = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic ts_we = 0, tl_we = 0, ps_we = 0, op_valid = 0, op_retry = 0, g_we = 0;
  logic [1:0]  ts_waddr = '0;
  logic [63:0] ts_wtpc = '0, ts_wtnpc = '0, ts_wtstate = '0, g_wdata = '0;
  logic [2:0]  tl_wdata = '0, g_widx = '0, g_ridx = '0;
  logic [11:0] ps_wdata = '0;

  logic [63:0] g_rdata, pc, npc;
  logic [3:0]  xcc, icc;
  logic [7:0]  asi;
  logic [11:0] pstate;
  logic [2:0]  cwp, tl;
  logic [1:0]  gbank;
  logic        irq_recheck, tl_err;

  logic [63:0] gl_rdata, gl_pc, gl_npc;
  logic [3:0]  gl_xcc, gl_icc;
  logic [7:0]  gl_asi;
  logic [11:0] gl_pstate;
  logic [2:0]  gl_cwp, gl_tl;
  logic [1:0]  gl_gbank;
  logic        gl_irq, gl_err;

  trap_return_unit #(.XW(XW), .NWIN(NWIN), .MAXTL(MAXTL), .NGREG(NGREG), .GL_ONLY(1'b0)) dut (
    .clk, .rst, .ts_we, .ts_waddr, .ts_wtpc, .ts_wtnpc, .ts_wtstate, .tl_we, .tl_wdata,
    .ps_we, .ps_wdata, .op_valid, .op_retry, .g_we, .g_widx, .g_wdata, .g_ridx,
    .g_rdata, .pc, .npc, .xcc, .icc, .asi, .pstate, .cwp, .tl, .gbank, .irq_recheck, .tl_err
  );

  trap_return_unit #(.XW(XW), .NWIN(NWIN), .MAXTL(MAXTL), .NGREG(NGREG), .GL_ONLY(1'b1)) dut_gl (
    .clk, .rst, .ts_we, .ts_waddr, .ts_wtpc, .ts_wtnpc, .ts_wtstate, .tl_we, .tl_wdata,
    .ps_we, .ps_wdata, .op_valid, .op_retry, .g_we, .g_widx, .g_wdata, .g_ridx,
    .g_rdata(gl_rdata), .pc(gl_pc), .npc(gl_npc), .xcc(gl_xcc), .icc(gl_icc), .asi(gl_asi),
    .pstate(gl_pstate), .cwp(gl_cwp), .tl(gl_tl), .gbank(gl_gbank), .irq_recheck(gl_irq), .tl_err(gl_err)
  );

  typedef struct packed {
    logic        retry;
    logic [63:0] tpc, tnpc, tst, epc, enpc;
    logic [7:0]  eccr, easi;
    logic [11:0] eps;
    logic [2:0]  ecwp;
    logic [1:0]  ebank;
    logic [11:0] egps;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 64'h1000, 64'h1004, 64'h0000_00A5_8000_1502, 64'h1004, 64'h1008,
      8'hA5, 8'h80, 12'h015, 3'd5, 2'd1, 12'h014},
    '{1'b1, 64'h2000, 64'h2004, 64'h0000_003C_140F_FF0B, 64'h2000, 64'h2004,
      8'h3C, 8'h14, 12'hF3F, 3'd4, 2'd0, 12'hF3E},
    '{1'b0, 64'hDEAD_0000, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0000_0000_FF04_0007,
      64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 8'h00, 8'hFF, 12'h400, 3'd0, 2'd2, 12'h400},
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDF3, 64'hABCD_EF96_0108_C0FF,
      64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDF3, 8'h96, 8'h01, 12'h800, 3'd0, 2'd3, 12'h800}
  };

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_tl(input logic [2:0] v);
    @(negedge clk); tl_we = 1; tl_wdata = v;
    @(negedge clk); tl_we = 0;
  endtask

  task automatic put_entry(input logic [1:0] a, input logic [63:0] p, input logic [63:0] n, input logic [63:0] s);
    @(negedge clk); ts_we = 1; ts_waddr = a; ts_wtpc = p; ts_wtnpc = n; ts_wtstate = s;
    @(negedge clk); ts_we = 0;
  endtask

  task automatic do_op(input logic r);
    @(negedge clk); op_valid = 1; op_retry = r;
    @(negedge clk); op_valid = 0;
    @(negedge clk);
  endtask

  task automatic wr_ps(input logic [11:0] v);
    @(negedge clk); ps_we = 1; ps_wdata = v;
    @(negedge clk); ps_we = 0;
  endtask

  task automatic wr_g(input logic [2:0] i, input logic [63:0] v);
    @(negedge clk); g_we = 1; g_widx = i; g_wdata = v;
    @(negedge clk); g_we = 0;
  endtask

  task automatic rd_g(input logic [2:0] i, input logic [63:0] exp, input string tag);
    @(negedge clk); g_ridx = i;
    @(negedge clk); chk(tag, g_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] pc_keep;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 pc", pc, 0); chk("R12 npc", npc, 0); chk("R12 tl", 64'(tl), 0);
    chk("R12 pstate", 64'(pstate), 0); chk("R12 gbank", 64'(gbank), 0);
    chk("R12 cwp", 64'(cwp), 0); chk("R12 flags", {xcc, icc, asi}, 0);
    chk("R12 pulses", {irq_recheck, tl_err}, 0);

    // Table of trap returns
    for (int i = 0; i < 4; i++) begin
      set_tl(3'd2);
      put_entry(2'd1, VECS[i].tpc, VECS[i].tnpc, VECS[i].tst);
      do_op(VECS[i].retry);
      chk(VECS[i].retry ? "R2 pc" : "R1 pc", pc, VECS[i].epc);
      chk(VECS[i].retry ? "R2 npc" : "R1 npc", npc, VECS[i].enpc);
      chk("R3 ccr", 64'({xcc, icc}), 64'(VECS[i].eccr));
      chk("R3 asi", 64'(asi), 64'(VECS[i].easi));
      chk("R4 pstate", 64'(pstate), 64'(VECS[i].eps));
      chk("R4 gl pstate", 64'(gl_pstate), 64'(VECS[i].egps));
      chk("R5 cwp", 64'(cwp), 64'(VECS[i].ecwp));
      chk("R6 tl", 64'(tl), 64'd1);
      chk("R7 gbank", 64'(gbank), 64'(VECS[i].ebank));
      chk("R10 recheck", 64'(irq_recheck), 64'd1);
      @(negedge clk);
      chk("R10 recheck one cycle", 64'(irq_recheck), 64'd0);
    end

    // R11: held request and processor-state write during apply are dropped
    set_tl(3'd2);
    put_entry(2'd1, 64'h5550, 64'h5554, 64'h0);
    put_entry(2'd0, 64'h6000, 64'h7000, 64'h0);
    @(negedge clk); op_valid = 1; op_retry = 1;
    @(negedge clk); ps_we = 1; ps_wdata = 12'h800;
    @(negedge clk); op_valid = 0; ps_we = 0;
    chk("R11 pc", pc, 64'h5550); chk("R11 tl", 64'(tl), 1);
    chk("R11 pstate", 64'(pstate), 0); chk("R11 gbank", 64'(gbank), 0);
    @(negedge clk);
    chk("R11 tl after hold", 64'(tl), 1); chk("R11 pc after hold", pc, 64'h5550);
    // R6: level 1 entry sits at address 0
    do_op(1'b0);
    chk("R6 level1 pc", pc, 64'h7000); chk("R6 level1 npc", npc, 64'h7004);
    chk("R6 tl zero", 64'(tl), 0);

    // R9: request at level 0
    pc_keep = pc;
    @(negedge clk); op_valid = 1; op_retry = 1;
    @(negedge clk); op_valid = 0;
    chk("R9 tl_err", 64'(tl_err), 1); chk("R9 no recheck", 64'(irq_recheck), 0);
    @(negedge clk);
    chk("R9 tl_err pulse", 64'(tl_err), 0); chk("R9 tl", 64'(tl), 0);
    chk("R9 pc", pc, pc_keep);

    // R8 / R10: direct processor-state write
    @(negedge clk); ps_we = 1; ps_wdata = 12'hFFF;
    @(negedge clk); ps_we = 0;
    chk("R8 pstate mask", 64'(pstate), 64'hF3F); chk("R10 ps recheck", 64'(irq_recheck), 1);
    chk("R8 gbank", 64'(gbank), 0);

    // R7: banks keep their contents
    wr_ps(12'h000); wr_g(3'd3, 64'h11);
    wr_ps(12'h001); wr_g(3'd3, 64'h22);
    chk("R7 alt bank", 64'(gbank), 1); chk("R4 gl bank", 64'(gl_gbank), 0);
    wr_ps(12'h400); wr_g(3'd3, 64'h33);
    wr_ps(12'h800); wr_g(3'd3, 64'h44);
    wr_ps(12'h401); chk("R7 fallback bank", 64'(gbank), 0);
    rd_g(3'd3, 64'h11, "R7 normal data");
    wr_ps(12'h800); rd_g(3'd3, 64'h44, "R7 intr data");
    wr_ps(12'h001); rd_g(3'd3, 64'h22, "R7 alt data");
    wr_ps(12'hC00); rd_g(3'd3, 64'h11, "R7 two-bit fallback data");
    wr_ps(12'h400); rd_g(3'd3, 64'h33, "R8 mmu data");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule